// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block is the controller-side engine that lands received frames in host memory through a ring of receive descriptors. Software writes the ring pointer word and pulses `init_i`. From then on the block polls the descriptor at the current ring index and waits for its owner bit to show that the controller may use it. It then prefetches that descriptor's buffer address and buffer length. Because of the prefetch, the next frame can stream straight into memory one byte per cycle, with no stall.

When the frame ends, the block writes the message byte count and then the status byte. The status byte clears the owner bit, which hands the descriptor back to the host. The block then raises a one-cycle receive interrupt and advances the ring index modulo the ring size. A frame may begin while no controller-owned descriptor has been loaded. In that case it is not stored, and a one-cycle missed pulse is raised. The memory port is byte wide, single ported and has a one-cycle read latency.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, and until the first `init_i`, the block issues no memory access and holds `rx_irq_o` and `missed_o` low. Frame bytes in this period are ignored.
- R2: `init_i` latches the ring pointer word and resets the ring index to 0. Bits 31:29 give log2 of the descriptor count, and bits 23:0 give the ring base. Descriptor i occupies 8 bytes starting at base + 8*i, laid out as follows:
  - bytes 0..2: buffer address, little endian
  - byte 3: status
  - bytes 4..5: buffer length, as a two's complement negative number, little endian
  - bytes 6..7: message byte count, little endian, low 12 bits valid
- R3: A descriptor whose status bit 7 (owner) is 0 belongs to the host and is never written. The block keeps polling it until the host sets the bit to 1.
- R4: Frame bytes are stored in arrival order at buffer address, buffer address + 1, and so on.
- R5: When a frame fits in its buffer, the status is written as 0x03 (owner 0, bit 1 start of packet, bit 0 end of packet). The message count is the number of bytes received, including the FCS bytes.
- R6: When a frame is longer than the buffer, the bytes beyond the buffer are discarded and memory past the buffer is left untouched. The message count saturates at the buffer length. The status is 0x52 (bit 6 error summary, bit 4 overflow, start of packet, no end of packet).
- R7: A CRC error flag present with the last byte sets status bit 3 (CRC error) and bit 6 (error summary). A fitting frame then gets status 0x4B.
- R8: After each descriptor is returned, the ring index advances modulo the descriptor count and wraps from the last descriptor back to descriptor 0.
- R9: The status byte is written after both message count bytes. `rx_irq_o` pulses for exactly one cycle, in the cycle after the status write, once per returned descriptor.
- R10: A frame whose first byte arrives while no controller-owned descriptor is loaded is not written anywhere. It causes a one-cycle `missed_o` pulse in the next cycle, and the rest of its bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Load ring pointer, reset index, start polling |
| ring_ptr_i | input | 32 | Ring pointer word: log2 count in 31:29, base in 23:0 |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_crc_err_i | input | 1 | CRC error, sampled with the last byte |
| ram_req_o | output | 1 | Memory access request |
| ram_we_o | output | 1 | Memory write enable |
| ram_addr_o | output | 24 | Memory byte address |
| ram_wdata_o | output | 8 | Memory write data |
| ram_rdata_i | input | 8 | Memory read data, valid one cycle after a read request |
| rx_irq_o | output | 1 | Descriptor returned to host |
| missed_o | output | 1 | Frame dropped, no descriptor available |

## Verification
The assertions take for granted that the byte stream has a sensible shape:
- the start marker appears only on the first byte of a frame;
- every frame is closed by an end marker;
- the memory answers every read in the following cycle.

They also take for granted that consecutive frames are separated by enough idle cycles for the write-back and the next descriptor prefetch to finish. The stimulus respects all of this. It drives whole frames from one task, pauses twenty cycles after each frame, and models the memory as a registered byte array. The only frame sent into an unprepared ring is sent on purpose, to provoke the missed-frame path.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int DESC_SHIFT = 3;          // 8 bytes per descriptor
  localparam int OFF_BADDR  = 0;          // 3 bytes, little endian
  localparam int OFF_STAT   = 3;
  localparam int OFF_BLEN   = 4;          // 2 bytes, negative length
  localparam int OFF_MLEN   = 6;          // 2 bytes, 12 valid bits
  localparam int FETCH_N    = 5;          // bytes prefetched after the owner check

  localparam int ST_OWN = 7;
  localparam int ST_ERR = 6;
  localparam int ST_FRM = 5;
  localparam int ST_OVF = 4;
  localparam int ST_CRC = 3;
  localparam int ST_BUF = 2;
  localparam int ST_STP = 1;
  localparam int ST_ENP = 0;

  typedef enum logic [2:0] {
    S_OFF, S_POLL, S_CHK, S_FETCH, S_READY, S_RECV, S_WB
  } rx_state_e;

  function automatic logic [7:0] status_byte(input logic ovf, input logic crc);
    logic [7:0] s;
    s         = '0;
    s[ST_STP] = 1'b1;
    s[ST_ENP] = ~ovf;
    s[ST_OVF] = ovf;
    s[ST_CRC] = crc;
    s[ST_ERR] = ovf | crc;
    return s;
  endfunction

  function automatic int fetch_off(input logic [2:0] step);
    case (step)
      3'd0:    return OFF_BADDR;
      3'd1:    return OFF_BADDR + 1;
      3'd2:    return OFF_BADDR + 2;
      3'd3:    return OFF_BLEN;
      default: return OFF_BLEN + 1;
    endcase
  endfunction
endpackage

// File: rtl/rx_ring_index.sv
module rx_ring_index
  import rx_ring_pkg::*;
#(
  parameter int AW    = 24,
  parameter int PTR_W = 32,
  parameter int LOGW  = 3,
  parameter int IDX_W = (1 << LOGW) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [PTR_W-1:0] ring_ptr_i,
  input  logic             adv_i,
  output logic [AW-1:0]    desc_addr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LOGW-1:0]  log2_o
);
  logic [AW-1:0]    base_q;
  logic [LOGW-1:0]  log2_q;
  logic [IDX_W-1:0] idx_q, mask;

  always_comb begin
    for (int i = 0; i < IDX_W; i++) mask[i] = (i < int'(log2_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      log2_q <= '0;
      idx_q  <= '0;
    end else if (init_i) begin
      base_q <= ring_ptr_i[AW-1:0];
      log2_q <= ring_ptr_i[PTR_W-1 -: LOGW];
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q  <= (idx_q + 1'b1) & mask;
    end
  end

  assign desc_addr_o = base_q + AW'({idx_q, {DESC_SHIFT{1'b0}}});
  assign idx_o       = idx_q;
  assign log2_o      = log2_q;
endmodule

// File: rtl/rx_ring_buf.sv
module rx_ring_buf #(
  parameter int AW     = 24,
  parameter int BAW    = 24,
  parameter int BLEN_W = 16,
  parameter int CNT_W  = 16,
  parameter int MLEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [2:0]        cap_sel_i,
  input  logic [7:0]        cap_data_i,
  input  logic              start_i,
  input  logic              take_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic              room_o,
  output logic [MLEN_W-1:0] mlen_o,
  output logic              ovf_o
);
  localparam int BAW_BYTES = BAW / 8;

  logic [BAW-1:0]    baddr_q;
  logic [BLEN_W-1:0] blen_q;
  logic [CNT_W-1:0]  cnt_q, cnt_cur, cnt_nxt, buf_len;
  logic              ovf_q;

  assign buf_len = CNT_W'(~blen_q + 1'b1);
  assign cnt_cur = start_i ? '0 : cnt_q;
  assign cnt_nxt = (&cnt_cur) ? cnt_cur : cnt_cur + 1'b1;
  assign room_o  = cnt_cur < buf_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baddr_q <= '0;
      blen_q  <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (cap_en_i) begin
        if (int'(cap_sel_i) < BAW_BYTES) baddr_q[8*cap_sel_i +: 8] <= cap_data_i;
        else blen_q[8*(cap_sel_i - 3'(BAW_BYTES)) +: 8] <= cap_data_i;
      end
      if (take_i) begin
        cnt_q <= cnt_nxt;
        ovf_q <= (start_i ? 1'b0 : ovf_q) | ~room_o;
      end
    end
  end

  assign wr_addr_o = AW'(baddr_q + BAW'(cnt_cur));
  assign mlen_o    = MLEN_W'((cnt_q < buf_len) ? cnt_q : buf_len);
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int AW     = 24,
  parameter int PTR_W  = 32,
  parameter int LOGW   = 3,
  parameter int CNT_W  = 16,
  parameter int MLEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [PTR_W-1:0] ring_ptr_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic             rx_crc_err_i,
  output logic             ram_req_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [7:0]       ram_wdata_o,
  input  logic [7:0]       ram_rdata_i,
  output logic             rx_irq_o,
  output logic             missed_o
);
  localparam int IDX_W   = (1 << LOGW) - 1;
  localparam int WB_LAST = 2;

  rx_state_e         state_q;
  logic [2:0]        step_q;
  logic              crc_q, irq_q, miss_q;
  logic [AW-1:0]     desc_addr, wr_addr;
  logic [IDX_W-1:0]  idx_w;
  logic [LOGW-1:0]   log2_w;
  logic [MLEN_W-1:0] mlen;
  logic              room, ovf;
  logic              start_ok, take, frame_end, miss, wb_last, cap_en;
  logic [15:0]       mlen16;

  assign start_ok  = (state_q == S_READY) && rx_valid_i && rx_sof_i;
  assign take      = start_ok || ((state_q == S_RECV) && rx_valid_i);
  assign frame_end = take && rx_eof_i;
  assign miss      = rx_valid_i && rx_sof_i &&
                     !(state_q inside {S_OFF, S_READY, S_RECV});
  assign wb_last   = (state_q == S_WB) && (step_q == 3'(WB_LAST));
  assign cap_en    = (state_q == S_FETCH) && (step_q != '0);
  assign mlen16    = 16'(mlen);

  rx_ring_index #(.AW(AW), .PTR_W(PTR_W), .LOGW(LOGW), .IDX_W(IDX_W)) u_index (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .ring_ptr_i  (ring_ptr_i),
    .adv_i       (wb_last && !init_i),
    .desc_addr_o (desc_addr),
    .idx_o       (idx_w),
    .log2_o      (log2_w)
  );

  rx_ring_buf #(.AW(AW), .CNT_W(CNT_W), .MLEN_W(MLEN_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en),
    .cap_sel_i  (step_q - 3'd1),
    .cap_data_i (ram_rdata_i),
    .start_i    (start_ok),
    .take_i     (take),
    .wr_addr_o  (wr_addr),
    .room_o     (room),
    .mlen_o     (mlen),
    .ovf_o      (ovf)
  );

  // memory port mux
  always_comb begin
    ram_req_o   = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    unique case (state_q)
      S_POLL: begin
        ram_req_o  = 1'b1;
        ram_addr_o = desc_addr + AW'(OFF_STAT);
      end
      S_FETCH: if (step_q < 3'(FETCH_N)) begin
        ram_req_o  = 1'b1;
        ram_addr_o = desc_addr + AW'(fetch_off(step_q));
      end
      S_READY, S_RECV: if (take && room) begin
        ram_req_o   = 1'b1;
        ram_we_o    = 1'b1;
        ram_addr_o  = wr_addr;
        ram_wdata_o = rx_data_i;
      end
      S_WB: begin
        ram_req_o = 1'b1;
        ram_we_o  = 1'b1;
        case (step_q)
          3'd0: begin
            ram_addr_o  = desc_addr + AW'(OFF_MLEN);
            ram_wdata_o = mlen16[7:0];
          end
          3'd1: begin
            ram_addr_o  = desc_addr + AW'(OFF_MLEN + 1);
            ram_wdata_o = mlen16[15:8];
          end
          default: begin // owner released last
            ram_addr_o  = desc_addr + AW'(OFF_STAT);
            ram_wdata_o = status_byte(ovf, crc_q);
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      step_q  <= '0;
      crc_q   <= 1'b0;
      irq_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      irq_q  <= wb_last && !init_i;
      miss_q <= miss;
      if (init_i) begin
        state_q <= S_POLL;
        step_q  <= '0;
        crc_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_OFF:  ;
          S_POLL: state_q <= S_CHK;
          S_CHK: begin
            step_q  <= '0;
            state_q <= ram_rdata_i[ST_OWN] ? S_FETCH : S_POLL;
          end
          S_FETCH: begin
            step_q <= step_q + 3'd1;
            if (step_q == 3'(FETCH_N)) state_q <= S_READY;
          end
          S_READY, S_RECV: begin
            if (start_ok) state_q <= S_RECV;
            if (frame_end) begin
              state_q <= S_WB;
              step_q  <= '0;
              crc_q   <= rx_crc_err_i;
            end
          end
          S_WB: begin
            step_q <= step_q + 3'd1;
            if (wb_last) state_q <= S_POLL;
          end
          default: state_q <= S_OFF;
        endcase
      end
    end
  end

  assign rx_irq_o = irq_q;
  assign missed_o = miss_q;
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int LOGW  = 3,
  parameter int IDX_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic             rx_valid_i,
  input logic             rx_sof_i,
  input logic             ram_req_o,
  input logic             ram_we_o,
  input logic [7:0]       ram_wdata_o,
  input logic             rx_irq_o,
  input logic             missed_o,
  input logic [IDX_W-1:0] idx_i,
  input logic [LOGW-1:0]  log2_i
);
  logic seen_init_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_init_q <= 1'b0;
    else if (init_i) seen_init_q <= 1'b1;
  end

  p_quiet_before_init_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_init_q |-> (!ram_req_o && !rx_irq_o && !missed_o));

  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  p_irq_after_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(ram_req_o && ram_we_o && !ram_wdata_o[7] && ram_wdata_o[1]));

  p_missed_on_sof_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missed_o |-> $past(rx_valid_i && rx_sof_i));

  p_idx_in_ring_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i >> log2_i) == '0);
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.LOGW(LOGW), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .rx_valid_i  (rx_valid_i),
  .rx_sof_i    (rx_sof_i),
  .ram_req_o   (ram_req_o),
  .ram_we_o    (ram_we_o),
  .ram_wdata_o (ram_wdata_o),
  .rx_irq_o    (rx_irq_o),
  .missed_o    (missed_o),
  .idx_i       (idx_w),
  .log2_i      (log2_w)
);

// File: tb/rx_ring_mgr_bench.sv
module rx_ring_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 2048;
  localparam int RING       = 'h100;
  localparam int BUFS       = 'h200;
  localparam int BLEN       = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [31:0] ring_ptr = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        ram_req, ram_we, rx_irq, missed;
  logic [23:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic [7:0]  mem [0:MEM_N-1];

  int tests = 0, fails = 0;
  int irq_cnt = 0, irq_hi = 0, miss_cnt = 0, pre_req = 0;
  logic inited = 1'b0, irq_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_mgr u_rx_ring_mgr (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .ring_ptr_i(ring_ptr),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_crc_err_i(rx_crc),
    .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .rx_irq_o(rx_irq), .missed_o(missed)
  );

  always @(posedge clk) begin
    if (ram_req) begin
      if (ram_we) mem[ram_addr[10:0]] <= ram_wdata;
      else ram_rdata <= mem[ram_addr[10:0]];
    end
    if (rst_n) begin
      if (rx_irq) irq_hi++;
      if (rx_irq && !irq_d) irq_cnt++;
      if (missed) miss_cnt++;
      if (ram_req && !inited) pre_req++;
    end
    irq_d <= rx_irq;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int ring, input int i, input int buf_a, input bit own);
    int d = ring + 8 * i;
    mem[d]   = buf_a[7:0];
    mem[d+1] = buf_a[15:8];
    mem[d+2] = 8'h00;
    mem[d+3] = own ? 8'h80 : 8'h00;
    mem[d+4] = 8'hE0;   // -32
    mem[d+5] = 8'hFF;
    mem[d+6] = 8'h00;
    mem[d+7] = 8'h00;
    for (int k = 0; k < BLEN + 8; k++) mem[buf_a + k] = 8'hEE;
  endtask

  task automatic do_init(input logic [31:0] ptr);
    @(negedge clk);
    init = 1'b1; ring_ptr = ptr; inited = 1'b1;
    @(negedge clk);
    init = 1'b0;
    idle(20);
  endtask

  task automatic send(input int n, input logic [7:0] seed, input bit crc);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(k);
      rx_sof = (k == 0); rx_eof = (k == n - 1); rx_crc = crc && (k == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc = 1'b0;
    idle(20);
  endtask

  function automatic int mlen_at(input int d);
    return int'({mem[d+7], mem[d+6]});
  endfunction

  task automatic t_reset;
    idle(3);
    send(4, 8'h10, 0);
    chk(pre_req, 0, "R1", "accesses before init");
    chk(irq_cnt, 0, "R1", "irq before init");
    chk(miss_cnt, 0, "R1", "missed before init");
  endtask

  task automatic t_fit;
    int b = BUFS, bad = 0;
    send(20, 8'h30, 0);
    for (int k = 0; k < 20; k++) if (mem[b + k] !== 8'h30 + 8'(k)) bad++;
    chk(bad, 0, "R4", "bytes in buffer 0");
    chk(mem[b + 20], 8'hEE, "R4", "byte past frame");
    chk(mem[RING + 3], 8'h03, "R5", "status fit");
    chk(mlen_at(RING), 20, "R5", "message count");
    chk(irq_cnt, 1, "R9", "irq count");
  endtask

  task automatic t_overflow;
    int b = BUFS + 'h40, bad = 0;
    send(40, 8'h50, 0);
    for (int k = 0; k < BLEN; k++) if (mem[b + k] !== 8'h50 + 8'(k)) bad++;
    chk(bad, 0, "R6", "stored part");
    chk(mem[b + BLEN], 8'hEE, "R6", "past buffer untouched");
    chk(mem[RING + 8 + 3], 8'h52, "R6", "status overflow");
    chk(mlen_at(RING + 8), BLEN, "R6", "count saturated");
  endtask

  task automatic t_crc;
    send(10, 8'h70, 1);
    chk(mem[RING + 16 + 3], 8'h4B, "R7", "status crc");
    chk(mlen_at(RING + 16), 10, "R7", "count crc");
  endtask

  task automatic t_missed;
    int b = BUFS + 'hC0;
    int irq0 = irq_cnt;
    send(6, 8'h90, 0);
    chk(miss_cnt, 1, "R10", "missed pulses");
    chk(mem[b], 8'hEE, "R10", "dropped frame not stored");
    chk(mem[RING + 24 + 3], 8'h00, "R3", "host descriptor untouched");
    chk(irq_cnt, irq0, "R10", "no irq on drop");
    mem[RING + 24 + 3] = 8'h80;
    idle(20);
    send(8, 8'hA0, 0);
    chk(mem[b], 8'hA0, "R3", "stored after owner set");
    chk(mem[RING + 24 + 3], 8'h03, "R3", "status after owner set");
  endtask

  task automatic t_wrap;
    mem[RING + 3] = 8'h80;
    idle(20);
    send(5, 8'hC0, 0);
    chk(mem[BUFS], 8'hC0, "R8", "wrap to descriptor 0");
    chk(mlen_at(RING), 5, "R8", "wrap count");
    chk(irq_cnt, 5, "R9", "irq per descriptor");
    chk(irq_hi, irq_cnt, "R9", "irq single cycle");
  endtask

  task automatic t_reinit;
    int r = 'h180, b = 'h600;
    put_desc(r, 0, b, 1);
    do_init({3'd0, 5'd0, 24'(r)});
    send(6, 8'hD0, 0);
    chk(mem[b + 5], 8'hD5, "R2", "new base buffer");
    chk(mem[r + 3], 8'h03, "R2", "new base status");
    mem[r + 3] = 8'h80;
    idle(20);
    send(3, 8'hE0, 1);
    chk(mlen_at(r), 3, "R8", "single-entry ring reuse");
    chk(mem[r + 3], 8'h4B, "R2", "single-entry ring status");
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    for (int i = 0; i < 4; i++) put_desc(RING, i, BUFS + 'h40 * i, i != 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    do_init({3'd2, 5'd0, 24'(RING)});
    t_fit;
    t_overflow;
    t_crc;
    t_missed;
    t_wrap;
    t_reinit;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule